// File: doc/BRIEF.md
# Read-to-Claim Hardware Spinlock Bank

This block holds a set of independent lock bits that several bus masters share to build mutual exclusion without any atomic instructions. Each lock sits at its own address. A read of that address is also a claim: if the lock is free, the read sets it and returns a one-hot word with the lock's bit set. If the lock is already held, the read returns zero and nothing changes. A write of any kind to the lock's address frees it. One more address returns the state of every lock as a bitmap and changes nothing.

Each master drives a simple request port (valid, write, address) and receives a registered response one cycle after each read. All locks are updated at the clock edge that captures the requests. Each lock is a two-state machine with states `LK_FREE` and `LK_HELD`. The `CLAIM` transition (`LK_FREE` to `LK_HELD`) fires when the lock's arbiter grants a read. The `RELEASE` transition (`LK_HELD` to `LK_FREE`) fires on a write. When several masters read the same free lock in the same cycle, the lowest-numbered port wins and every other port gets zero. A write to a lock in the same cycle as a read of it takes precedence: the read fails and the lock ends free. Each read response has one of three kinds: `RSP_LOCK`, `RSP_STATUS` or `RSP_HOLE`. `RSP_NONE` marks a cycle with no read.

With defaults, lock i is at address i (0 to 31), the status word is at address 32, and addresses 33 to 63 are unmapped. Write data is not used, so the bus data lines need not reach the block.

Top module: `spinlock_bank`

## Requirements
- R1: After reset every lock is free, so a status read returns 0 and any lock can be claimed.
- R2: A read of free lock i (address i) with no competing winner and no same-cycle write returns exactly 1<<i and leaves lock i held.
- R3: A read of a held lock returns 0 and the lock stays held. This holds for the master that claimed it too: locks are not re-entrant.
- R4: A write to address i (i below NUM_LOCKS) frees lock i from the next cycle on, whatever the previous state.
- R5: A read of the status address (address NUM_LOCKS) returns a word whose bit i is 1 when lock i was held in the request cycle, and it changes no lock.
- R6: When several ports read the same free lock in one cycle, the lowest-numbered port gets 1<<i and every other port gets 0.
- R7: When a lock is written and read in the same cycle, the read returns 0 and the lock ends free.
- R8: Reads of different free locks by different ports in the same cycle all succeed, each returning its own one-hot value.
- R9: `rsp_valid[p]` is 1 in the cycle after a read on port p and 0 otherwise. Writes produce no response.
- R10: Reads of unmapped addresses (above NUM_LOCKS) return 0. Writes to unmapped addresses or to the status address change no lock.
- R11: A lock is never granted to two requesters at once, under any interleaving of claims and releases from all ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; frees all locks |
| bus_valid | input | NUM_PORTS | Per-port request strobe |
| bus_write | input | NUM_PORTS | Per-port request type: 1 write (release), 0 read (claim or status) |
| bus_addr | input | NUM_PORTS*ADDR_W | Per-port address; port p uses bits [p*ADDR_W +: ADDR_W] |
| rsp_valid | output | NUM_PORTS | Per-port read response strobe, one cycle after the read |
| rsp_data | output | NUM_PORTS*DATA_W | Per-port read data; port p uses bits [p*DATA_W +: DATA_W] |

## Verification
The hardest situations to reach from the ports are collisions within one cycle: two ports reading the same free lock, and one port writing a lock while the other reads it. These only show up when both ports are driven in the same cycle. Directed steps set up each collision on purpose, on locks whose state is known beforehand. A long run of random two-port traffic then does the rest. That traffic is concentrated on six locks and mixed with status and unmapped accesses, so contests and release-versus-claim races happen often. A scoreboard predicts every read result from a reference model, and separately checks that no one lock is ever handed to both ports.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

    // State of a single lock bit.
    typedef enum logic {
        LK_FREE = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    // What a port's request will produce as a read response.
    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_LOCK   = 2'd1,
        RSP_STATUS = 2'd2,
        RSP_HOLE   = 2'd3
    } rsp_kind_e;

endpackage

// File: rtl/spinlock_decode.sv
module spinlock_decode
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic [NUM_LOCKS-1:0] claim_vec,
    output logic [NUM_LOCKS-1:0] release_vec,
    output rsp_kind_e            rsp_kind
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_LOCKS);

    logic is_read;
    logic is_write;
    logic in_lock_range;

    assign is_read       = req_valid && !req_write;
    assign is_write      = req_valid && req_write;
    assign in_lock_range = (req_addr < STATUS_ADDR);

    // One claim line and one release line per lock address.
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock_sel
        assign claim_vec[i]   = is_read  && (req_addr == ADDR_W'(i));
        assign release_vec[i] = is_write && (req_addr == ADDR_W'(i));
    end

    // Classify the read, if any, for the response path.
    always_comb begin
        rsp_kind = RSP_NONE;
        if (is_read) begin
            if (in_lock_range) begin
                rsp_kind = RSP_LOCK;
            end else if (req_addr == STATUS_ADDR) begin
                rsp_kind = RSP_STATUS;
            end else begin
                rsp_kind = RSP_HOLE;
            end
        end
    end

endmodule

// File: rtl/spinlock_arbiter.sv
module spinlock_arbiter #(
    parameter int NUM_PORTS = 2
) (
    input  logic [NUM_PORTS-1:0] claim_req,
    input  logic                 lock_free,
    input  logic                 release_hit,
    output logic [NUM_PORTS-1:0] grant
);

    // Fixed priority: lowest port index wins. No grant when the lock is
    // held or a release lands on it in the same cycle.
    always_comb begin
        grant = '0;
        if (lock_free && !release_hit) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (claim_req[p] && (grant == '0)) begin
                    grant[p] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spinlock_cell.sv
module spinlock_cell
    import spinlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic drop,
    output logic held
);

    lock_state_e state_q;
    lock_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: CLAIM and RELEASE transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: if (take) state_d = LK_HELD;
            LK_HELD: if (drop) state_d = LK_FREE;
        endcase
    end

    // Output.
    always_comb begin
        held = (state_q == LK_HELD);
    end

endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
    import spinlock_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(NUM_LOCKS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        bus_valid,
    input  logic [NUM_PORTS-1:0]        bus_write,
    input  logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [NUM_PORTS*DATA_W-1:0] rsp_data
);

    logic [NUM_LOCKS-1:0] port_claim   [NUM_PORTS];
    logic [NUM_LOCKS-1:0] port_release [NUM_PORTS];
    logic [NUM_LOCKS-1:0] port_won     [NUM_PORTS];
    rsp_kind_e            port_kind    [NUM_PORTS];

    logic [NUM_PORTS-1:0] lock_claim [NUM_LOCKS];
    logic [NUM_PORTS-1:0] lock_grant [NUM_LOCKS];
    logic [NUM_LOCKS-1:0] lock_drop;
    logic [NUM_LOCKS-1:0] lock_held;

    // Per-port address decode.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_dec
        spinlock_decode #(
            .NUM_LOCKS (NUM_LOCKS),
            .ADDR_W    (ADDR_W)
        ) dec_i (
            .req_valid   (bus_valid[p]),
            .req_write   (bus_write[p]),
            .req_addr    (bus_addr[p*ADDR_W +: ADDR_W]),
            .claim_vec   (port_claim[p]),
            .release_vec (port_release[p]),
            .rsp_kind    (port_kind[p])
        );
    end

    // Transpose port-major requests into lock-major ones and back for grants.
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_xpose
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bit
            assign lock_claim[i][p] = port_claim[p][i];
            assign port_won[p][i]   = lock_grant[i][p];
        end
    end

    // A release from any port hits the lock.
    always_comb begin
        lock_drop = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            lock_drop = lock_drop | port_release[p];
        end
    end

    // One arbiter and one state machine per lock.
    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        spinlock_arbiter #(
            .NUM_PORTS (NUM_PORTS)
        ) arb_i (
            .claim_req   (lock_claim[i]),
            .lock_free   (!lock_held[i]),
            .release_hit (lock_drop[i]),
            .grant       (lock_grant[i])
        );

        spinlock_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (|lock_grant[i]),
            .drop  (lock_drop[i]),
            .held  (lock_held[i])
        );
    end

    // Registered response per port. A port addresses one lock at a time,
    // so its grant vector is one-hot or zero.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
        logic [DATA_W-1:0] rsp_next;
        logic [DATA_W-1:0] data_q;
        logic              valid_q;

        always_comb begin
            rsp_next = '0;
            unique case (port_kind[p])
                RSP_LOCK:   rsp_next[NUM_LOCKS-1:0] = port_won[p];
                RSP_STATUS: rsp_next[NUM_LOCKS-1:0] = lock_held;
                RSP_HOLE:   rsp_next = '0;
                RSP_NONE:   rsp_next = '0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else begin
                valid_q <= (port_kind[p] != RSP_NONE);
                data_q  <= rsp_next;
            end
        end

        assign rsp_valid[p]                  = valid_q;
        assign rsp_data[p*DATA_W +: DATA_W]  = data_q;
    end

endmodule

// File: rtl/spinlock_bank_chk.sv
module spinlock_bank_chk #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS-1:0]        bus_valid,
    input logic [NUM_PORTS-1:0]        bus_write,
    input logic [NUM_PORTS*ADDR_W-1:0] bus_addr,
    input logic [NUM_PORTS-1:0]        rsp_valid,
    input logic [NUM_PORTS*DATA_W-1:0] rsp_data,
    input logic [NUM_LOCKS-1:0]        lock_held
);

    localparam int LIDX_W = $clog2(NUM_LOCKS);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_LOCKS);

    logic [NUM_PORTS-1:0] rd_lock;
    logic [NUM_PORTS-1:0] rd_status;
    logic [NUM_PORTS-1:0] rd_hole;
    logic [NUM_PORTS-1:0] wr_lock;
    logic [NUM_PORTS-1:0] last_lock_q;
    logic [LIDX_W-1:0]    port_idx [NUM_PORTS];
    logic [NUM_LOCKS-1:0] read_hit_any;
    logic [NUM_LOCKS-1:0] wr_hit_any;
    logic [NUM_PORTS-1:0] win_bits [NUM_LOCKS];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cls
        logic [ADDR_W-1:0] a;
        assign a            = bus_addr[p*ADDR_W +: ADDR_W];
        assign port_idx[p]  = a[LIDX_W-1:0];
        assign rd_lock[p]   = bus_valid[p] && !bus_write[p] && (a < STATUS_ADDR);
        assign rd_status[p] = bus_valid[p] && !bus_write[p] && (a == STATUS_ADDR);
        assign rd_hole[p]   = bus_valid[p] && !bus_write[p] && (a > STATUS_ADDR);
        assign wr_lock[p]   = bus_valid[p] && bus_write[p] && (a < STATUS_ADDR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_lock_q <= '0;
        end else begin
            last_lock_q <= rd_lock;
        end
    end

    always_comb begin
        read_hit_any = '0;
        wr_hit_any   = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_lock[p]) read_hit_any[port_idx[p]] = 1'b1;
            if (wr_lock[p]) wr_hit_any[port_idx[p]]   = 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LOCKS; i++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                win_bits[i][p] = last_lock_q[p] && rsp_data[p*DATA_W + i];
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        // R9
        read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid[p] && !bus_write[p]) |=> rsp_valid[p]);
        // R9
        no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_valid[p] && !bus_write[p]) |=> !rsp_valid[p]);
        // R2
        claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_lock[p] |=> $onehot0(rsp_data[p*DATA_W +: DATA_W]));
        // R3
        held_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lock[p] && lock_held[port_idx[p]]) |=> (rsp_data[p*DATA_W +: DATA_W] == '0));
        // R7
        race_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_lock[p] && wr_hit_any[port_idx[p]]) |=> (rsp_data[p*DATA_W +: DATA_W] == '0));
        // R5
        status_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_status[p] |=> (rsp_data[p*DATA_W +: NUM_LOCKS] == $past(lock_held)));
        // R10
        hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hole[p] |=> (rsp_data[p*DATA_W +: DATA_W] == '0));
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock_chk
        // R4
        release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit_any[i] |=> !lock_held[i]);
        // R2
        set_only_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lock_held[i] |=> (!lock_held[i] || $past(read_hit_any[i])));
        // R11
        single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(win_bits[i]) <= 1);
    end

    if (NUM_PORTS >= 2) begin : g_pri_chk
        logic same_free;
        assign same_free = rd_lock[0] && rd_lock[1] && (port_idx[0] == port_idx[1])
                           && !lock_held[port_idx[0]] && !wr_hit_any[port_idx[0]];
        // R6
        low_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            same_free |=> ((rsp_data[0 +: DATA_W] != '0) && (rsp_data[DATA_W +: DATA_W] == '0)));
    end

endmodule

bind spinlock_bank spinlock_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_LOCKS (NUM_LOCKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .lock_held (lock_held)
);

// File: tb/spinlock_bank_tb_top.sv
module spinlock_bank_tb_top;

    localparam int NP = 2;
    localparam int NL = 32;
    localparam int DW = 32;
    localparam int AW = 6;

    logic             clk;
    logic             rst_n;
    logic [NP-1:0]    bus_valid;
    logic [NP-1:0]    bus_write;
    logic [NP*AW-1:0] bus_addr;
    logic [NP-1:0]    rsp_valid;
    logic [NP*DW-1:0] rsp_data;

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
        bit            is_lock;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];

    int            checks = 0;
    int            fails  = 0;
    logic [NL-1:0] ref_state;

    spinlock_bank #(
        .NUM_PORTS (NP),
        .NUM_LOCKS (NL),
        .DATA_W    (DW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic push(input int p, input logic [DW-1:0] v, input string t, input bit lk);
        exp_t it;
        it.val = v;
        it.tag = t;
        it.is_lock = lk;
        if (p == 0) q0.push_back(it);
        else        q1.push_back(it);
    endtask

    // Driver: predict from the reference model, queue expectations, drive.
    task automatic step(input bit v0, input bit w0, input int a0, input string t0,
                        input bit v1, input bit w1, input int a1, input string t1);
        bit            v[2];
        bit            w[2];
        int            a[2];
        string         t[2];
        logic [NL-1:0] rel;
        logic [NL-1:0] taken;
        logic [DW-1:0] e;
        v[0] = v0; w[0] = w0; a[0] = a0; t[0] = t0;
        v[1] = v1; w[1] = w1; a[1] = a1; t[1] = t1;
        rel = '0;
        taken = '0;
        for (int p = 0; p < 2; p++) begin
            if (v[p] && w[p] && a[p] < NL) rel[a[p]] = 1'b1;
        end
        for (int p = 0; p < 2; p++) begin
            if (v[p] && !w[p]) begin
                if (a[p] < NL) begin
                    if (!ref_state[a[p]] && !rel[a[p]] && !taken[a[p]]) begin
                        e = 32'h1 << a[p];
                        taken[a[p]] = 1'b1;
                    end else begin
                        e = '0;
                    end
                end else if (a[p] == NL) begin
                    e = ref_state;
                end else begin
                    e = '0;
                end
                push(p, e, t[p], a[p] < NL);
            end
        end
        ref_state = (ref_state | taken) & ~rel;
        bus_valid = {v1, v0};
        bus_write = {w1, w0};
        bus_addr  = {AW'(a1), AW'(a0)};
        @(negedge clk);
    endtask

    // Monitor: compare each response with the queued expectation.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [DW-1:0] lock_got [2];
            for (int p = 0; p < 2; p++) begin
                lock_got[p] = '0;
                if (rsp_valid[p]) begin
                    exp_t          it;
                    logic [DW-1:0] got;
                    got = rsp_data[p*DW +: DW];
                    checks++;
                    if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
                        fails++;
                        $display("FAIL R9 port%0d: got response %h expected none", p, got);
                    end else begin
                        if (p == 0) it = q0.pop_front();
                        else        it = q1.pop_front();
                        if (got !== it.val) begin
                            fails++;
                            $display("FAIL %s port%0d: got %h expected %h", it.tag, p, got, it.val);
                        end
                        if (it.is_lock) lock_got[p] = got;
                    end
                end
            end
            if (lock_got[0] != '0 && lock_got[1] != '0) begin
                checks++;
                if ((lock_got[0] & lock_got[1]) != '0) begin
                    fails++;
                    $display("FAIL R11 double grant: got %h and %h expected disjoint",
                             lock_got[0], lock_got[1]);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL R9 watchdog expired: got hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_valid = '0;
        bus_write = '0;
        bus_addr = '0;
        ref_state = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: status clear after reset, lock 0 claimable.
        step(1, 0, 32, "R1", 1, 0, 0, "R1");
        // Free lock 0 again.
        step(1, 1, 0, "", 0, 0, 0, "");
        // R2: claim lock 5.
        step(1, 0, 5, "R2", 0, 0, 0, "");
        // R2 status shows bit 5; R3 other port fails on held lock.
        step(1, 0, 32, "R2", 1, 0, 5, "R3");
        // R3: holder re-claims and fails.
        step(1, 0, 5, "R3", 0, 0, 0, "");
        // R4: release from the other port (R9: no response to writes).
        step(0, 0, 0, "", 1, 1, 5, "");
        step(1, 0, 32, "R4", 1, 0, 5, "R4");
        // R6: both ports contend for free lock 9.
        step(1, 0, 9, "R6", 1, 0, 9, "R6");
        // R8: different locks at the boundaries.
        step(1, 0, 0, "R8", 1, 0, 31, "R8");
        // R7: read and write on free lock 12 in one cycle.
        step(1, 0, 12, "R7", 1, 1, 12, "");
        step(0, 0, 0, "", 1, 0, 12, "R7");
        // R7: read and write on held lock 31.
        step(1, 1, 31, "", 1, 0, 31, "R7");
        step(1, 0, 31, "R7", 0, 0, 0, "");
        // R5: status reads have no side effects.
        step(1, 0, 32, "R5", 1, 0, 32, "R5");
        step(1, 0, 32, "R5", 0, 0, 0, "");
        step(1, 0, 3, "R5", 0, 0, 0, "");
        // R10: unmapped read and writes to unmapped/status addresses.
        step(1, 0, 40, "R10", 1, 1, 45, "");
        step(1, 1, 32, "", 1, 0, 63, "R10");
        step(1, 0, 32, "R10", 0, 0, 0, "");

        // R11: random concurrent traffic against the reference model.
        for (int n = 0; n < 3000; n++) begin
            bit vv[2];
            bit ww[2];
            int aa[2];
            for (int p = 0; p < 2; p++) begin
                int r;
                vv[p] = ($urandom % 4) != 0;
                ww[p] = ($urandom % 10) < 3;
                r = $urandom % 16;
                if (r < 10)      aa[p] = r % 6;
                else if (r < 12) aa[p] = 31;
                else if (r < 14) aa[p] = 32;
                else             aa[p] = 40 + r;
            end
            step(vv[0], ww[0], aa[0], "R11", vv[1], ww[1], aa[1], "R11");
        end

        bus_valid = '0;
        bus_write = '0;
        repeat (3) @(negedge clk);
        // R9: every expected response arrived.
        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            fails++;
            $display("FAIL R9 pending: got %0d/%0d left expected 0/0", q0.size(), q1.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule